// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This block compares two IEEE-754 operands and records the outcome as a 2-bit condition code in a floating-point status register that it holds. A precision input selects single precision (the low 32 bits of each operand bus) or double precision (all 64 bits). A field-select input picks one of four condition-code fields in the status register as the destination. When a strobe is raised, the block clears the chosen field, writes the new code there, and decides what to do about NaN operands.

If either operand is a NaN, the result is unordered. An unordered result then either raises a one-cycle trap request or sets a sticky accrued invalid-operation flag. A trap-enable bit held in the same status register makes that choice. Software sets the trap-enable bit, or restores any other state, by loading the whole status register through a load port. Arithmetic and rounding are not part of this block.

Top module: `fcmp_cc_unit`

## Requirements
- R1: After reset the status register reads all zeros and the trap request is low.
- R2: One clock edge after `start` is sampled high (and `sr_load` low), the selected field holds the comparison code: 0 for equal, 1 for first operand less, 2 for first operand greater and 3 for unordered. Whatever the field held before is replaced.
- R3: Field 0 occupies status bits [11:10]. Fields 1, 2 and 3 occupy bits [33:32], [35:34] and [37:36]. A compare changes no status bit outside the selected field, except the accrued flag of R9.
- R4: A NaN has an all-ones exponent and a nonzero fraction. Both quiet and signaling NaNs in either operand give code 3.
- R5: Positive zero and negative zero compare as equal.
- R6: Non-NaN operands are ordered by sign and magnitude. A negative value is less than a positive one. Between two negatives, the larger magnitude is the smaller value. Equal infinities are equal.
- R7: With `dbl_sel` low, only bits [31:0] of each operand are used (sign 31, exponent 30:23, fraction 22:0) and the upper bits have no effect. With `dbl_sel` high, all 64 bits are used (sign 63, exponent 62:52, fraction 51:0).
- R8: On an unordered result with trap-enable bit 27 set, code 3 is written and `trap_req` is high for exactly the one cycle in which that status update appears. Accrued bit 9 is left unchanged.
- R9: On an unordered result with bit 27 clear, accrued bit 9 is set and no trap is raised. Ordered compares leave bit 9 as it was.
- R10: `sr_load` writes `sr_wdata` into the status register on the next edge. When it coincides with `start`, the load wins: the compare is dropped and no trap is raised.
- R11: With neither `start` nor `sr_load`, the status register holds its value and `trap_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| dbl_sel | input | 1 | 1 = double precision, 0 = single (low 32 bits) |
| fld_sel | input | 2 | Destination condition field, 0 to 3 |
| start | input | 1 | Compare strobe |
| sr_load | input | 1 | Load the status register from `sr_wdata` |
| sr_wdata | input | 64 | Status register load value |
| sr_q | output | 64 | Status register |
| trap_req | output | 1 | One-cycle invalid-operation trap request |

## Verification
The compare is driven with ordinary positive pairs in both orders, with signed zeros of opposite sign, with two negatives, and with a mixed-sign pair. These patterns separate a correct signed ordering from a plain magnitude comparison or an unsigned integer comparison. A single-precision pair carrying garbage in its upper bits tells apart correct handling of the low half from an accidental read of the full word. Double-precision infinities and a quiet NaN exercise the wide format, and a single-precision signaling NaN checks the fraction test on the narrow one. Reusing a field checks that stale bits are cleared. The same NaN compare is run with the trap-enable bit set and then clear, which shows whether a trap is raised or the accrued flag is set. A load that collides with a start shows which of the two has priority.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  // IEEE-754 format geometry
  localparam int SP_W    = 32;
  localparam int SP_EXP  = 8;
  localparam int SP_FRAC = 23;
  localparam int DP_W    = 64;
  localparam int DP_EXP  = 11;
  localparam int DP_FRAC = 52;
  localparam int MAG_W   = DP_W - 1;

  typedef enum logic [1:0] {
    CC_EQ = 2'd0,
    CC_LT = 2'd1,
    CC_GT = 2'd2,
    CC_UN = 2'd3
  } cc_e;

  typedef struct packed {
    logic             sign;
    logic             nan;
    logic             zero;
    logic [MAG_W-1:0] mag;
  } opnd_t;

  // Split a raw operand into sign, magnitude and class flags.
  function automatic opnd_t decode_op(input logic [DP_W-1:0] raw, input logic dbl);
    opnd_t o;
    if (dbl) begin
      o.sign = raw[DP_W-1];
      o.mag  = raw[MAG_W-1:0];
      o.nan  = (&raw[DP_W-2 -: DP_EXP]) && (|raw[DP_FRAC-1:0]);
    end else begin
      o.sign = raw[SP_W-1];
      o.mag  = {{(MAG_W-SP_W+1){1'b0}}, raw[SP_W-2:0]};
      o.nan  = (&raw[SP_W-2 -: SP_EXP]) && (|raw[SP_FRAC-1:0]);
    end
    o.zero = (o.mag == '0);
    return o;
  endfunction

  // Sign-magnitude ordering with NaN detection.
  function automatic cc_e order_cc(input opnd_t x, input opnd_t y);
    if (x.nan || y.nan)       return CC_UN;
    if (x.zero && y.zero)     return CC_EQ;
    if (x.sign != y.sign)     return x.sign ? CC_LT : CC_GT;
    if (x.mag == y.mag)       return CC_EQ;
    if ((x.mag < y.mag) ^ x.sign) return CC_LT;
    return CC_GT;
  endfunction

  // Bit position of a condition field.
  function automatic int field_pos(input int k, input int base, input int hi_ofs);
    return (k == 0) ? base : base + hi_ofs + 2 * k;
  endfunction

endpackage

// File: rtl/fcmp_operand_decode.sv
module fcmp_operand_decode
  import fcmp_pkg::*;
(
  input  logic [DP_W-1:0] raw,
  input  logic            dbl,
  output opnd_t           dec
);
  assign dec = decode_op(raw, dbl);
endmodule

// File: rtl/fcmp_order_cmp.sv
module fcmp_order_cmp
  import fcmp_pkg::*;
(
  input  opnd_t a_dec,
  input  opnd_t b_dec,
  output cc_e   code,
  output logic  unord
);
  assign code  = order_cc(a_dec, b_dec);
  assign unord = a_dec.nan | b_dec.nan;
endmodule

// File: rtl/fcmp_sr_update.sv
module fcmp_sr_update
  import fcmp_pkg::*;
#(
  parameter int SR_W    = 64,
  parameter int NFIELD  = 4,
  parameter int CC_BASE = 10,
  parameter int HI_OFS  = 20,
  parameter int TE_BIT  = 27,
  parameter int ACC_BIT = 9,
  localparam int SEL_W  = $clog2(NFIELD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             load,
  input  logic [SR_W-1:0]  wdata,
  input  logic [SEL_W-1:0] sel,
  input  cc_e              code,
  input  logic             unord,
  output logic [SR_W-1:0]  sr_q,
  output logic             trap_q
);
  logic [NFIELD-1:0][SR_W-1:0] fmask;
  logic [SR_W-1:0] sr_d;
  logic            trap_d;

  genvar gk;
  generate
    for (gk = 0; gk < NFIELD; gk++) begin : g_mask
      localparam int P = field_pos(gk, CC_BASE, HI_OFS);
      assign fmask[gk] = {{(SR_W-2){1'b0}}, 2'b11} << P;
    end
  endgenerate

  always_comb begin
    sr_d   = sr_q;
    trap_d = 1'b0;
    if (load) begin
      sr_d = wdata;
    end else if (fire) begin
      for (int k = 0; k < NFIELD; k++) begin
        if (sel == SEL_W'(k)) begin
          sr_d = (sr_q & ~fmask[k]) |
                 ({{(SR_W-2){1'b0}}, code} << field_pos(k, CC_BASE, HI_OFS));
        end
      end
      if (unord) begin
        if (sr_q[TE_BIT]) trap_d = 1'b1;
        else              sr_d[ACC_BIT] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      trap_q <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      trap_q <= trap_d;
    end
  end
endmodule

// File: rtl/fcmp_cc_unit.sv
module fcmp_cc_unit
  import fcmp_pkg::*;
#(
  parameter int SR_W    = 64,
  parameter int NFIELD  = 4,
  parameter int CC_BASE = 10,
  parameter int HI_OFS  = 20,
  parameter int TE_BIT  = 27,
  parameter int ACC_BIT = 9,
  localparam int SEL_W  = $clog2(NFIELD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [63:0]      op_a,
  input  logic [63:0]      op_b,
  input  logic             dbl_sel,
  input  logic [SEL_W-1:0] fld_sel,
  input  logic             start,
  input  logic             sr_load,
  input  logic [SR_W-1:0]  sr_wdata,
  output logic [SR_W-1:0]  sr_q,
  output logic             trap_req
);
  opnd_t       dec [2];
  logic [63:0] raw [2];
  cc_e         cmp_code;
  logic        cmp_unord;
  logic        cmp_fire;

  assign raw[0]   = op_a;
  assign raw[1]   = op_b;
  assign cmp_fire = start & ~sr_load;

  genvar gi;
  generate
    for (gi = 0; gi < 2; gi++) begin : g_dec
      fcmp_operand_decode u_dec (
        .raw (raw[gi]),
        .dbl (dbl_sel),
        .dec (dec[gi])
      );
    end
  endgenerate

  fcmp_order_cmp u_cmp (
    .a_dec (dec[0]),
    .b_dec (dec[1]),
    .code  (cmp_code),
    .unord (cmp_unord)
  );

  fcmp_sr_update #(
    .SR_W(SR_W), .NFIELD(NFIELD), .CC_BASE(CC_BASE),
    .HI_OFS(HI_OFS), .TE_BIT(TE_BIT), .ACC_BIT(ACC_BIT)
  ) u_sr (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (cmp_fire),
    .load   (sr_load),
    .wdata  (sr_wdata),
    .sel    (fld_sel),
    .code   (cmp_code),
    .unord  (cmp_unord),
    .sr_q   (sr_q),
    .trap_q (trap_req)
  );
endmodule

// File: rtl/fcmp_cc_checker.sv
module fcmp_cc_checker #(
  parameter int SR_W    = 64,
  parameter int CC_BASE = 10,
  parameter int HI_OFS  = 20,
  parameter int TE_BIT  = 27,
  parameter int ACC_BIT = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            sr_load,
  input logic [SR_W-1:0] sr_wdata,
  input logic [1:0]      fld_sel,
  input logic [SR_W-1:0] sr_q,
  input logic            trap_req,
  input logic [1:0]      cmp_code,
  input logic            cmp_unord
);
  function automatic int pos_of(input logic [1:0] s);
    return (s == 2'd0) ? CC_BASE : CC_BASE + HI_OFS + 2 * int'(s);
  endfunction

  function automatic logic [SR_W-1:0] keep_mask(input logic [1:0] s);
    logic [SR_W-1:0] m;
    m = '1;
    m[pos_of(s)]     = 1'b0;
    m[pos_of(s) + 1] = 1'b0;
    m[ACC_BIT]       = 1'b0;
    return m;
  endfunction

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !sr_load) |=> ($stable(sr_q) && !trap_req));

  assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sr_load |=> (sr_q == $past(sr_wdata) && !trap_req));

  assert_code_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !sr_load) |=> (sr_q[pos_of($past(fld_sel)) +: 2] == $past(cmp_code)));

  assert_other_bits_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !sr_load) |=>
      ((sr_q & keep_mask($past(fld_sel))) == ($past(sr_q) & keep_mask($past(fld_sel)))));

  assert_trap_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> ($past(start && !sr_load) && $past(sr_q[TE_BIT]) &&
                  sr_q[pos_of($past(fld_sel)) +: 2] == 2'b11));

  assert_trap_raised_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !sr_load && cmp_unord && sr_q[TE_BIT]) |=>
      (trap_req && sr_q[ACC_BIT] == $past(sr_q[ACC_BIT])));

  assert_accrue_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !sr_load && cmp_unord && !sr_q[TE_BIT]) |=> (sr_q[ACC_BIT] && !trap_req));

  assert_accrue_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_q[ACC_BIT] && !sr_load) |=> sr_q[ACC_BIT]);
endmodule

bind fcmp_cc_unit fcmp_cc_checker #(
  .SR_W(SR_W), .CC_BASE(CC_BASE), .HI_OFS(HI_OFS),
  .TE_BIT(TE_BIT), .ACC_BIT(ACC_BIT)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .sr_load   (sr_load),
  .sr_wdata  (sr_wdata),
  .fld_sel   (fld_sel),
  .sr_q      (sr_q),
  .trap_req  (trap_req),
  .cmp_code  (cmp_code),
  .cmp_unord (cmp_unord)
);

// File: tb/fcmp_cc_unit_tb.sv
module fcmp_cc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic        dbl_sel = 1'b0;
  logic [1:0]  fld_sel = '0;
  logic        start = 1'b0;
  logic        sr_load = 1'b0;
  logic [63:0] sr_wdata = '0;
  logic [63:0] sr_q;
  logic        trap_req;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  logic [63:0] exp_sr = '0;

  always #2.5 clk = ~clk;

  fcmp_cc_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .dbl_sel(dbl_sel),
    .fld_sel(fld_sel), .start(start), .sr_load(sr_load), .sr_wdata(sr_wdata),
    .sr_q(sr_q), .trap_req(trap_req)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Field k lives at 10 for k=0, otherwise at 32 + 2*(k-1).
  function automatic int bench_pos(input int k);
    if (k == 0) return 10;
    return 32 + 2 * (k - 1);
  endfunction

  task automatic do_cmp(input string tag, input logic [63:0] a, input logic [63:0] b,
                        input logic dbl, input int k, input logic [1:0] code);
    logic exp_trap;
    exp_trap = 1'b0;
    exp_sr[bench_pos(k)]     = code[0];
    exp_sr[bench_pos(k) + 1] = code[1];
    if (code == 2'd3) begin
      if (exp_sr[27]) exp_trap = 1'b1;
      else            exp_sr[9] = 1'b1;
    end
    @(negedge clk);
    op_a = a; op_b = b; dbl_sel = dbl; fld_sel = 2'(k); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({tag, " status"}, sr_q, exp_sr);
    check({tag, " trap"}, {63'b0, trap_req}, {63'b0, exp_trap});
    if (exp_trap) begin
      @(negedge clk);
      check({tag, " R8 trap one cycle"}, {63'b0, trap_req}, 64'd0);
    end
  endtask

  task automatic do_load(input string tag, input logic [63:0] v, input logic with_start);
    @(negedge clk);
    sr_wdata = v; sr_load = 1'b1; start = with_start;
    op_a = 64'h7FF8_0000_0000_0000; op_b = '0; dbl_sel = 1'b1; fld_sel = 2'd1;
    @(negedge clk);
    sr_load = 1'b0; start = 1'b0;
    exp_sr = v;
    check({tag, " status"}, sr_q, exp_sr);
    check({tag, " trap"}, {63'b0, trap_req}, 64'd0);
  endtask

  task automatic do_idle(input string tag, input int n);
    repeat (n) @(negedge clk);
    check({tag, " status"}, sr_q, exp_sr);
    check({tag, " trap"}, {63'b0, trap_req}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset status", sr_q, 64'd0);
    check("R1 reset trap", {63'b0, trap_req}, 64'd0);

    // Ordering in single precision
    do_cmp("R2 R6 1<2 fld0", 64'h3F80_0000, 64'h4000_0000, 1'b0, 0, 2'd1);
    do_cmp("R3 R6 2>1 fld1", 64'h4000_0000, 64'h3F80_0000, 1'b0, 1, 2'd2);
    do_cmp("R5 -0==+0 fld2", 64'h8000_0000, 64'h0000_0000, 1'b0, 2, 2'd0);
    do_cmp("R6 -2<-1 fld3", 64'hC000_0000, 64'hBF80_0000, 1'b0, 3, 2'd1);
    do_cmp("R6 -1<1 fld2", 64'hBF80_0000, 64'h3F80_0000, 1'b0, 2, 2'd1);
    do_cmp("R7 single ignores upper", 64'hFFFF_FFFF_3F80_0000, 64'h3F80_0000, 1'b0, 1, 2'd0);
    // Double precision
    do_cmp("R7 dbl 1>-inf fld0", 64'h3FF0_0000_0000_0000, 64'hFFF0_0000_0000_0000, 1'b1, 0, 2'd2);
    do_cmp("R6 dbl inf==inf fld3", 64'h7FF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, 1'b1, 3, 2'd0);
    // NaN handling with trap disabled
    do_cmp("R4 R9 dbl qNaN fld2", 64'h7FF8_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1'b1, 2, 2'd3);
    do_cmp("R4 single sNaN fld0", 64'h0, 64'h7F80_0001, 1'b0, 0, 2'd3);
    do_cmp("R2 R9 clear then write fld0", 64'h4000_0000, 64'h4000_0000, 1'b0, 0, 2'd0);
    // Trap enabled
    do_load("R10 load te", 64'h0000_0000_0800_0000, 1'b0);
    do_cmp("R8 trap NaN fld1", 64'h3F80_0000, 64'h7FC0_0000, 1'b0, 1, 2'd3);
    do_cmp("R8 ordered no trap", 64'h3F80_0000, 64'h3F80_0000, 1'b0, 1, 2'd0);
    // Load colliding with start
    do_load("R10 load beats start", 64'h0000_0030_0000_0C00, 1'b1);
    do_idle("R11 idle hold", 4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule